// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller

This block collects up to 128 level-sensitive interrupt lines, arranged in banks of 32, and presents one interrupt request to a processor. Software reaches it through a simple 32-bit register bus. The bus has a write strobe, an address, write data and combinational read data. Each bank has a mask register. It also has two ports that set or clear mask bits where the data has a 1, and a read-only view of its lines that are asserted and unmasked.

When nothing is active, the controller picks the lowest-numbered pending line whose priority is below a programmable threshold. It latches that line's number and raises `cpu_irq`. The number and the request stay fixed until software writes the acknowledge bit, even if the line falls or is masked in the meantime. After the acknowledge, the controller chooses again. The block also has a software-triggered reset with a completion flag, an autoidle configuration bit, a version register, protection and idle configuration registers, and one level register per line.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After `rst_n` is low, every bank mask reads 0xFFFFFFFF (all lines masked) and `cpu_irq` is 0. The active register (0x40) reads 0, the threshold (0x68) reads 0xFF, status (0x14) bit 0 reads 1, every level register reads 0, and the version register (0x00) reads 0x21 (major version in bits [7:4], minor version in bits [3:0]).
- R2: For bank n, the mask register sits at 0x84+0x20·n and can be read and written directly. A write to 0x88+0x20·n clears (unmasks) each mask bit whose data bit is 1. A write to 0x8C+0x20·n sets (masks) each mask bit whose data bit is 1. Zero data bits leave the mask unchanged, and both of these ports read 0.
- R3: The read-only register at 0x98+0x20·n returns the bank's input lines ANDed with the inverse of its mask.
- R4: While no interrupt is latched, the controller latches on the next clock edge the lowest-numbered pending line whose priority (bits [7:2] of its level register) is numerically below threshold bits [7:0]. `cpu_irq` is then 1. When no line qualifies, nothing is latched.
- R5: The active register at 0x40 returns the latched line number in bits [6:0], or 0 when nothing is latched. The number and `cpu_irq` hold until acknowledged, even if the line drops or is masked.
- R6: A write to 0x48 with data bit 0 set acknowledges the latch. `cpu_irq` is 0 in the following cycle, and a new choice can be latched one edge later. A write to 0x48 with bit 0 clear has no effect, and 0x48 reads 0.
- R7: Writing 1 to bit 1 of the configuration register (0x10) starts a soft reset. Every register returns to its R1 value and any latch is dropped. For 4 cycles, configuration bit 1 reads 1, status bit 0 reads 0, and bus writes are ignored. After that, bit 1 reads 0 and status bit 0 reads 1.
- R8: The following read back the last value written: configuration bit 0 (autoidle), protection (0x4C) bit 0, idle (0x50) bits [1:0], threshold bits [7:0], and the level register of line i at 0x100+4·i, bits [7:0]. All other bits, and unmapped addresses, read 0.
- R9: Bank registers for banks at or above NUM_LINES/32, and level registers for lines at or above NUM_LINES, read 0 and ignore writes. With the default of 96 lines this covers bank 3, for example 0xE4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_lines | input | NUM_LINES | Level-sensitive interrupt inputs |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
The assertions watch the following on every cycle:
- the latch holds its number until an acknowledge or soft reset;
- a newly latched number always refers to a pending line;
- an acknowledge drops the request in the next cycle;
- the set and clear mask ports reach exactly the written bits;
- the soft-reset window keeps every mask at its default.

Some behaviours need chosen stimulus and only the bench's scenarios can show them. These are the lowest-number choice under the threshold and priority filter, the exact four-cycle length of the soft reset and the writes ignored during it, and the registers that stay silent beyond the configured bank count. A long random phase, compared every clock against a behavioural model, covers mixes of masking, acknowledges and priority changes.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // register byte addresses
  localparam int ADR_VERSION = 'h000;
  localparam int ADR_CFG     = 'h010;
  localparam int ADR_STAT    = 'h014;
  localparam int ADR_ACTIVE  = 'h040;
  localparam int ADR_ACK     = 'h048;
  localparam int ADR_PROT    = 'h04C;
  localparam int ADR_IDLE    = 'h050;
  localparam int ADR_THRESH  = 'h068;
  localparam int ADR_BANK0   = 'h084;
  localparam int BANK_STRIDE = 'h020;
  localparam int ADR_LEVEL0  = 'h100;

  // offsets inside one bank window
  localparam int BOFF_MASK    = 'h00;
  localparam int BOFF_UNMASK  = 'h04;
  localparam int BOFF_MASKSET = 'h08;
  localparam int BOFF_PEND    = 'h14;

  localparam int LINES_PER_BANK = 32;
  localparam int LEVEL_W        = 8;
  localparam int PRIO_W         = 6;

  function automatic int bank_adr(int bank, int off);
    return ADR_BANK0 + bank * BANK_STRIDE + off;
  endfunction

  function automatic int level_adr(int line);
    return ADR_LEVEL0 + 4 * line;
  endfunction

  // priority field sits in bits [7:2] of a level register
  function automatic logic [PRIO_W-1:0] prio_of(logic [LEVEL_W-1:0] lv);
    return lv[7:2];
  endfunction

  // a smaller priority value is more urgent; it must be strictly below threshold
  function automatic logic beats_threshold(logic [PRIO_W-1:0] prio, logic [7:0] thr);
    return {2'b00, prio} < thr;
  endfunction
endpackage

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int BANK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_direct,
  input  logic              wr_unmask,
  input  logic              wr_mask,
  input  logic [BANK_W-1:0] wdata,
  input  logic [BANK_W-1:0] lines,
  output logic [BANK_W-1:0] mask_q,
  output logic [BANK_W-1:0] pend
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr)   mask_q <= '1;
    else if (wr_direct)  mask_q <= wdata;
    else if (wr_unmask)  mask_q <= mask_q & ~wdata;
    else if (wr_mask)    mask_q <= mask_q | wdata;
  end

  assign pend = lines & ~mask_q;

  // R2
  maskset_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask && !clr) |=> ((mask_q & $past(wdata)) == $past(wdata)));

  // R2
  unmask_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_unmask && !clr) |=> ((mask_q & $past(wdata)) == '0));
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N    = 96,
  parameter int ID_W = 7
) (
  input  logic [N-1:0]                 pend,
  input  logic [N*irq_pkg::PRIO_W-1:0] prio_flat,
  input  logic [7:0]                   thr,
  output logic                         found,
  output logic [ID_W-1:0]              id
);
  localparam int PW = irq_pkg::PRIO_W;

  // scan from the top so that the lowest qualifying index wins
  always_comb begin
    found = 1'b0;
    id    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i] && irq_pkg::beats_threshold(prio_flat[i*PW +: PW], thr)) begin
        found = 1'b1;
        id    = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_srst.sv
module irq_srst #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (start)        cnt_q <= CNT_W'(CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  // R7
  srst_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  // R7
  srst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl #(
  parameter int         NUM_LINES   = 96,
  parameter int         SRST_CYCLES = 4,
  parameter int         ADDR_W      = 12,
  parameter logic [3:0] REV_MAJOR   = 4'd2,
  parameter logic [3:0] REV_MINOR   = 4'd1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_LINES-1:0] irq_lines,
  output logic                 cpu_irq
);
  import irq_pkg::*;

  localparam int BW        = LINES_PER_BANK;
  localparam int NUM_BANKS = NUM_LINES / BW;
  localparam int ID_W      = $clog2(NUM_LINES);
  localparam int PW        = PRIO_W;

  // ---- bus events ----
  logic srst_busy;
  logic bus_wr;
  logic srst_start;
  logic ack_evt;
  logic soft_clear;

  assign bus_wr     = bus_we && !srst_busy;
  assign srst_start = bus_wr && (bus_addr == ADDR_W'(ADR_CFG)) && bus_wdata[1];
  assign ack_evt    = bus_wr && (bus_addr == ADDR_W'(ADR_ACK)) && bus_wdata[0];
  assign soft_clear = srst_start || srst_busy;

  irq_srst #(.CYCLES(SRST_CYCLES)) u_srst (
    .clk   (clk),
    .rst_n (rst_n),
    .start (srst_start),
    .busy  (srst_busy)
  );

  // ---- simple configuration registers ----
  logic       autoidle_q;
  logic       prot_q;
  logic [1:0] idle_q;
  logic [7:0] thr_q;

  always_ff @(posedge clk) begin
    if (!rst_n || soft_clear) begin
      autoidle_q <= 1'b0;
      prot_q     <= 1'b0;
      idle_q     <= 2'b00;
      thr_q      <= 8'hFF;
    end else if (bus_wr) begin
      if (bus_addr == ADDR_W'(ADR_CFG))    autoidle_q <= bus_wdata[0];
      if (bus_addr == ADDR_W'(ADR_PROT))   prot_q     <= bus_wdata[0];
      if (bus_addr == ADDR_W'(ADR_IDLE))   idle_q     <= bus_wdata[1:0];
      if (bus_addr == ADDR_W'(ADR_THRESH)) thr_q      <= bus_wdata[7:0];
    end
  end

  // ---- per-bank masks ----
  logic [BW-1:0]        mask_q [NUM_BANKS];
  logic [NUM_LINES-1:0] pend_flat;
  logic [NUM_LINES-1:0] mask_flat;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit_direct, hit_unmask, hit_mask;
    assign hit_direct = bus_wr && (bus_addr == ADDR_W'(bank_adr(b, BOFF_MASK)));
    assign hit_unmask = bus_wr && (bus_addr == ADDR_W'(bank_adr(b, BOFF_UNMASK)));
    assign hit_mask   = bus_wr && (bus_addr == ADDR_W'(bank_adr(b, BOFF_MASKSET)));

    irq_mask_bank #(.BANK_W(BW)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (soft_clear),
      .wr_direct (hit_direct),
      .wr_unmask (hit_unmask),
      .wr_mask   (hit_mask),
      .wdata     (bus_wdata),
      .lines     (irq_lines[b*BW +: BW]),
      .mask_q    (mask_q[b]),
      .pend      (pend_flat[b*BW +: BW])
    );
    assign mask_flat[b*BW +: BW] = mask_q[b];
  end

  // ---- per-line level registers ----
  logic [LEVEL_W-1:0]      lvl_q [NUM_LINES];
  logic [NUM_LINES*PW-1:0] prio_flat;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_LINES; i++) begin
      if (!rst_n || soft_clear)
        lvl_q[i] <= '0;
      else if (bus_wr && (bus_addr == ADDR_W'(level_adr(i))))
        lvl_q[i] <= bus_wdata[LEVEL_W-1:0];
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) prio_flat[i*PW +: PW] = prio_of(lvl_q[i]);
  end

  // ---- choice of the next active line ----
  logic            pick_found;
  logic [ID_W-1:0] pick_id;

  irq_pick #(.N(NUM_LINES), .ID_W(ID_W)) u_pick (
    .pend      (pend_flat),
    .prio_flat (prio_flat),
    .thr       (thr_q),
    .found     (pick_found),
    .id        (pick_id)
  );

  logic            act_valid;
  logic [ID_W-1:0] act_id;
  logic            latch_evt;

  assign latch_evt = !act_valid && pick_found && !soft_clear && !ack_evt;

  always_ff @(posedge clk) begin
    if (!rst_n || soft_clear) begin
      act_valid <= 1'b0;
      act_id    <= '0;
    end else if (ack_evt) begin
      act_valid <= 1'b0;
    end else if (latch_evt) begin
      act_valid <= 1'b1;
      act_id    <= pick_id;
    end
  end

  assign cpu_irq = act_valid;

  // ---- read mux ----
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(ADR_VERSION): bus_rdata = {24'h0, REV_MAJOR, REV_MINOR};
      ADDR_W'(ADR_CFG):     bus_rdata = {30'h0, srst_busy, autoidle_q};
      ADDR_W'(ADR_STAT):    bus_rdata = {31'h0, !srst_busy};
      ADDR_W'(ADR_ACTIVE):  bus_rdata = act_valid ? 32'(act_id) : 32'h0;
      ADDR_W'(ADR_PROT):    bus_rdata = {31'h0, prot_q};
      ADDR_W'(ADR_IDLE):    bus_rdata = {30'h0, idle_q};
      ADDR_W'(ADR_THRESH):  bus_rdata = {24'h0, thr_q};
      default: ;
    endcase
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bus_addr == ADDR_W'(bank_adr(b, BOFF_MASK))) bus_rdata = mask_q[b];
      if (bus_addr == ADDR_W'(bank_adr(b, BOFF_PEND))) bus_rdata = pend_flat[b*BW +: BW];
    end
    for (int i = 0; i < NUM_LINES; i++) begin
      if (bus_addr == ADDR_W'(level_adr(i))) bus_rdata = 32'(lvl_q[i]);
    end
  end

  // ---- assertions ----
  // R5
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && !ack_evt && !soft_clear) |=> (act_valid && act_id == $past(act_id)));

  // R4
  pick_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_evt |-> pend_flat[pick_id]);

  // R4
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_valid && !pick_found) |=> !act_valid);

  // R6
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_evt |=> !cpu_irq);

  // R7
  srst_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_busy |-> (&mask_flat && !cpu_irq));
endmodule

// File: tb/test_irq_bank_ctrl.sv
module test_irq_bank_ctrl;
  localparam int NL   = 96;
  localparam int NB   = NL / 32;
  localparam int SRST = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_we = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NL-1:0] irq_lines = '0;
  logic          cpu_irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  irq_bank_ctrl i_irq_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_lines(irq_lines),
    .cpu_irq(cpu_irq)
  );

  // ---------------- behavioural reference ----------------
  bit [31:0] m_mask [4];
  bit [7:0]  m_lvl  [NL];
  bit [7:0]  m_thr;
  bit        m_auto, m_prot, m_val;
  bit [1:0]  m_idle;
  int        m_busy, m_id;

  task automatic m_defaults();
    foreach (m_mask[b]) m_mask[b] = 32'hFFFF_FFFF;
    foreach (m_lvl[i]) m_lvl[i] = 8'h00;
    m_thr = 8'hFF; m_auto = 0; m_prot = 0; m_idle = 0; m_val = 0; m_id = 0;
  endtask

  task automatic m_write(logic [11:0] a, logic [31:0] d);
    int ai;
    ai = int'(a);
    if (ai == 'h10) m_auto = d[0];
    if (ai == 'h4C) m_prot = d[0];
    if (ai == 'h50) m_idle = d[1:0];
    if (ai == 'h68) m_thr  = d[7:0];
    if (ai >= 'h84 && ai < 'h84 + 32 * NB) begin
      if ((ai - 'h84) % 32 == 0) m_mask[(ai - 'h84) / 32] = d;
      if ((ai - 'h84) % 32 == 4) m_mask[(ai - 'h84) / 32] &= ~d;
      if ((ai - 'h84) % 32 == 8) m_mask[(ai - 'h84) / 32] |= d;
    end
    if (ai >= 'h100 && ai < 'h100 + 4 * NL && ai % 4 == 0) m_lvl[(ai - 'h100) / 4] = d[7:0];
  endtask

  function automatic logic [31:0] m_read(logic [11:0] a);
    int ai;
    ai = int'(a);
    if (ai == 'h00) return 32'h21;
    if (ai == 'h10) return {30'h0, m_busy != 0, m_auto};
    if (ai == 'h14) return {31'h0, m_busy == 0};
    if (ai == 'h40) return m_val ? 32'(m_id) : 32'h0;
    if (ai == 'h4C) return {31'h0, m_prot};
    if (ai == 'h50) return {30'h0, m_idle};
    if (ai == 'h68) return {24'h0, m_thr};
    if (ai >= 'h84 && ai < 'h84 + 32 * NB) begin
      if ((ai - 'h84) % 32 == 0)    return m_mask[(ai - 'h84) / 32];
      if ((ai - 'h84) % 32 == 'h14) return irq_lines[((ai - 'h84) / 32) * 32 +: 32] & ~m_mask[(ai - 'h84) / 32];
      return 32'h0;
    end
    if (ai >= 'h100 && ai < 'h100 + 4 * NL && ai % 4 == 0) return 32'(m_lvl[(ai - 'h100) / 4]);
    return 32'h0;
  endfunction

  function automatic string tag_of(logic [11:0] a);
    int ai;
    ai = int'(a);
    if (ai == 'h00) return "R1";
    if (ai == 'h10 || ai == 'h14) return "R7";
    if (ai == 'h40) return "R5";
    if (ai >= 'h84 && ai < 'h84 + 32 * NB && (ai - 'h84) % 32 == 'h14) return "R3";
    if (ai >= 'h84 && ai < 'h84 + 32 * NB) return "R2";
    return "R8";
  endfunction

  always @(posedge clk) begin
    bit f;
    int pid;
    if (!rst_n) begin
      m_defaults(); m_busy = 0;
    end else if (m_busy > 0) begin
      m_busy--;
    end else begin
      f = 0; pid = 0;
      for (int i = NL - 1; i >= 0; i--)
        if (irq_lines[i] && !m_mask[i / 32][i % 32] && int'(m_lvl[i][7:2]) < int'(m_thr)) begin
          f = 1; pid = i;
        end
      if (bus_we && bus_addr == 12'h010 && bus_wdata[1]) begin
        m_defaults(); m_busy = SRST;
      end else begin
        if (bus_we && bus_addr == 12'h048 && bus_wdata[0]) m_val = 0;
        else if (!m_val && f) begin m_val = 1; m_id = pid; end
        if (bus_we) m_write(bus_addr, bus_wdata);
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // every clock: request line and read data against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4 cpu_irq", {31'h0, cpu_irq}, {31'h0, m_val});
      chk({tag_of(bus_addr), " rdata"}, bus_rdata, m_read(bus_addr));
    end
  end

  // inputs change at posedge+5; tasks start and end in that phase
  task automatic step(int n);
    repeat (n) begin @(posedge clk); #5; end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #5;
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(string req, logic [11:0] a, logic [31:0] exp);
    bus_addr = a; #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    rd("R1", 12'h000, 32'h21);
    rd("R1", 12'h084, 32'hFFFF_FFFF);
    rd("R1", 12'h0C4, 32'hFFFF_FFFF);
    rd("R1", 12'h014, 32'h1);
    rd("R1", 12'h068, 32'hFF);
    rd("R1", 12'h040, 32'h0);
    rd("R1", 12'h10C, 32'h0);
    chk("R1 cpu_irq", {31'h0, cpu_irq}, 32'h0);

    // R9 bank 3 and line 100 absent with 96 lines
    wr(12'h0E8, 32'hFFFF_FFFF);
    rd("R9", 12'h0E4, 32'h0);
    wr(12'h290, 32'hAA);
    rd("R9", 12'h290, 32'h0);

    // R2 mask ports
    wr(12'h088, 32'h0000_0F00);
    rd("R2", 12'h084, 32'hFFFF_F0FF);
    wr(12'h08C, 32'h0000_0100);
    rd("R2", 12'h084, 32'hFFFF_F1FF);
    wr(12'h088, 32'h0);
    rd("R2", 12'h084, 32'hFFFF_F1FF);
    rd("R2", 12'h088, 32'h0);
    wr(12'h084, 32'hFFFF_F0FF);
    rd("R2", 12'h084, 32'hFFFF_F0FF);

    // R3 pending view, R4 first choice
    irq_lines = '0; irq_lines[9] = 1; irq_lines[12] = 1; irq_lines[40] = 1;
    rd("R3", 12'h098, 32'h0000_0200);
    rd("R3", 12'h0B8, 32'h0);
    step(1);
    rd("R4", 12'h040, 32'd9);
    chk("R4 cpu_irq", {31'h0, cpu_irq}, 32'h1);

    // R5 hold despite line drop; R6 zero-bit ack has no effect
    irq_lines = '0; irq_lines[10] = 1; irq_lines[12] = 1;
    step(2);
    rd("R5", 12'h040, 32'd9);
    wr(12'h048, 32'h0);
    rd("R6", 12'h040, 32'd9);
    rd("R6", 12'h048, 32'h0);
    wr(12'h048, 32'h1);
    chk("R6 cpu_irq after ack", {31'h0, cpu_irq}, 32'h0);
    step(1);
    rd("R6", 12'h040, 32'd10);

    // R4 priority and threshold
    irq_lines = '0; irq_lines[8] = 1; irq_lines[11] = 1;
    wr(12'h120, 32'hFC);
    wr(12'h12C, 32'h20);
    wr(12'h068, 32'h10);
    wr(12'h048, 32'h1);
    step(1);
    rd("R4", 12'h040, 32'd11);
    wr(12'h068, 32'h08);
    wr(12'h048, 32'h1);
    step(3);
    chk("R4 none qualifies", {31'h0, cpu_irq}, 32'h0);
    rd("R4", 12'h040, 32'h0);

    // R3/R5 upper bank line
    irq_lines = '0; irq_lines[70] = 1;
    wr(12'h068, 32'hFF);
    wr(12'h0C8, 32'h40);
    step(1);
    rd("R3", 12'h0D8, 32'h40);
    rd("R5", 12'h040, 32'd70);
    irq_lines = '0;
    wr(12'h048, 32'h1);

    // R8 plain registers
    wr(12'h010, 32'h1);   rd("R8", 12'h010, 32'h1);
    wr(12'h04C, 32'hFFFF_FFFF); rd("R8", 12'h04C, 32'h1);
    wr(12'h050, 32'hFFFF_FFFF); rd("R8", 12'h050, 32'h3);
    wr(12'h068, 32'h1234); rd("R8", 12'h068, 32'h34);
    wr(12'h114, 32'hFFFF); rd("R8", 12'h114, 32'hFF);
    rd("R8", 12'h200, 32'h0);

    // R7 soft reset
    wr(12'h010, 32'h3);
    rd("R7", 12'h010, 32'h2);
    rd("R7", 12'h014, 32'h0);
    rd("R7", 12'h084, 32'hFFFF_FFFF);
    wr(12'h088, 32'hFFFF_FFFF);
    step(2);
    rd("R7", 12'h014, 32'h0);
    step(1);
    rd("R7", 12'h014, 32'h1);
    rd("R7", 12'h010, 32'h0);
    rd("R7", 12'h084, 32'hFFFF_FFFF);
    rd("R7", 12'h068, 32'hFF);
    rd("R7", 12'h114, 32'h0);

    // random mix compared every clock against the model
    for (int b = 0; b < NB; b++) wr(12'(32'h88 + 32 * b), 32'hFFFF_FFFF);
    for (int n = 0; n < 3000; n++) begin
      int op;
      if ($urandom_range(3) == 0) irq_lines[$urandom_range(NL - 1)] ^= 1'b1;
      op = int'($urandom_range(19));
      bus_we = 1'b0;
      bus_wdata = $urandom;
      case (op)
        0, 1:    begin bus_we = 1; bus_addr = 12'(32'h88 + 32 * $urandom_range(NB - 1)); end
        2:       begin bus_we = 1; bus_addr = 12'(32'h8C + 32 * $urandom_range(NB - 1)); end
        3, 4, 5: begin bus_we = 1; bus_addr = 12'h048; end
        6:       begin bus_we = 1; bus_addr = 12'(32'h100 + 4 * $urandom_range(NL - 1)); end
        7:       begin bus_we = 1; bus_addr = 12'h068; bus_wdata[7] = 1'b1; end
        8:       begin bus_we = ($urandom_range(15) == 0); bus_addr = 12'h010; end
        9:       bus_addr = 12'(32'h98 + 32 * $urandom_range(NB - 1));
        10:      bus_addr = 12'(32'h100 + 4 * $urandom_range(NL - 1));
        default: bus_addr = 12'h040;
      endcase
      @(posedge clk); #5;
    end
    bus_we = 1'b0;
    step(2);
    summary();
    $finish;
  end
endmodule